// File: doc/BRIEF.md
# Byte-Handshake Shift-Register Transfer Engine

This block carries packets between a host processor and a peripheral controller one byte at a time. It uses no serial clock. Instead, the host moves two active-low handshake lines, transfer-in-progress and acknowledge, and every change of either line while a transfer is active moves one whole byte through an 8-bit shift-data register. The block answers on an active-low request line and raises a shift-register interrupt flag at each byte boundary and when a transfer ends.

In the host-to-device direction, each handshake change copies the shift-data register into the next slot of an outbound packet buffer. When in-progress is released, a one-cycle packet-complete strobe reports how many bytes were captured. In the device-to-host direction, a loader first fills the inbound buffer and commits a length. Request then goes low, and each handshake change places the next inbound byte in the shift-data register for the host to read. While the link is idle, request follows acknowledge, which lets the two sides synchronise.

Handshake and mode writes are not acted on at once. They are evaluated in the clock cycle after the write, and each evaluation compares the current handshake pair with the pair seen at the previous evaluation.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After synchronous reset, req_n is 1, sr_flag is 0, sd_q is 0, pkt_done is 0 and pkt_len is 0. Both handshake lines are taken as deasserted (1), and the mode is device-to-host.
- R2: With mode_host_tx=1 and in-progress asserted (hs_tip_n=0), an evaluation in which tip_n or ack_n differs from the previous evaluated pair stores sd_q in the next outbound slot, starting at slot 0, and sets sr_flag.
- R3: An evaluation in which neither handshake line has changed moves no byte and leaves sr_flag unchanged.
- R4: The outbound buffer holds DEPTH (16) bytes. A handshake change when it is full stores nothing, leaves sr_flag unchanged, and the packet length stays 16.
- R5: With mode_host_tx=0, in-progress asserted and inbound bytes unread, a handshake change loads the next inbound byte into sd_q and sets sr_flag. With no bytes unread, a change does nothing.
- R6: When the last inbound byte is loaded into sd_q, req_n goes to 1.
- R7: While in-progress is deasserted and was deasserted at the previous evaluation, a change of ack_n copies ack_n to req_n and sets sr_flag.
- R8: At the evaluation where in-progress becomes deasserted, sr_flag is set. pkt_done pulses for one cycle with pkt_len equal to the captured byte count only if that count is non-zero, and the outbound index returns to 0.
- R9: At an evaluation with in-progress deasserted, no acknowledge toggle under R7, and inbound bytes unread, req_n goes to 0.
- R10: in_load commits in_len (clamped to DEPTH), rewinds the inbound read index to 0, sets sr_flag and schedules a handshake evaluation.
- R11: flag_clr clears sr_flag. When the flag is set in the same cycle, the set wins.
- R12: A write by hs_we, mode_we or in_load is evaluated in the following cycle, so the outputs change one clock after the edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_we | input | 1 | Write strobe for the handshake pair |
| hs_tip_n | input | 1 | Transfer-in-progress from the host, active low |
| hs_ack_n | input | 1 | Acknowledge from the host, active low |
| mode_we | input | 1 | Write strobe for the direction mode |
| mode_host_tx | input | 1 | 1: host-to-device, 0: device-to-host |
| sd_we | input | 1 | Host write of the shift-data register |
| sd_wdata | input | DW | Shift-data write value |
| flag_clr | input | 1 | Clears the shift-register interrupt flag |
| in_wr_en | input | 1 | Loader write into the inbound buffer |
| in_wr_addr | input | AW | Inbound buffer write slot |
| in_wr_data | input | DW | Inbound buffer write byte |
| in_load | input | 1 | Commit an inbound packet |
| in_len | input | IW | Inbound packet length |
| out_rd_addr | input | AW | Outbound buffer read slot |
| out_rd_data | output | DW | Outbound byte, registered, one cycle after the address |
| req_n | output | 1 | Transfer request to the host, active low |
| sd_q | output | DW | Shift-data register |
| sr_flag | output | 1 | Shift-register interrupt flag |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_len | output | IW | Byte count of the last completed packet |

## Verification
The hardest state to reach is a full outbound buffer. Getting there takes sixteen accepted bytes, each with its own shift-data write followed by an alternating acknowledge toggle, and then a seventeenth toggle that must leave no trace. The bench walks through this sequence, clears the flag just before the extra toggle, and closes the transfer to read back the length of 16 and the last stored byte. A second hard case is a flag clear that lands in the same cycle as an inbound commit. The bench pulses both inputs on the same edge.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  // Handshake pair as written by the host, both active low.
  typedef struct packed {
    logic tip_n;
    logic ack_n;
  } hs_t;

  localparam hs_t HS_IDLE = '{tip_n: 1'b1, ack_n: 1'b1};
endpackage

// File: rtl/hsk_buf.sv
module hsk_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_we,
  input  hs_t           hs_in,
  input  logic          mode_we,
  input  logic          mode_tx,
  input  logic          sd_we,
  input  logic [DW-1:0] sd_wdata,
  input  logic          flag_clr,
  input  logic          in_load,
  input  logic [IW-1:0] in_len,
  input  logic [DW-1:0] in_rd_data,
  output logic [AW-1:0] in_rd_addr,
  output logic          ob_we,
  output logic [AW-1:0] ob_addr,
  output logic [DW-1:0] ob_wdata,
  output logic          req_n,
  output logic [DW-1:0] sd_q,
  output logic          flag,
  output logic          pkt_done,
  output logic [IW-1:0] pkt_len
);
  localparam logic [IW-1:0] FULL = IW'(DEPTH);

  hs_t           hs_q, hs_last;
  logic          tx_mode, eval_pend;
  logic [IW-1:0] out_idx, in_idx, in_len_q;

  logic fire, moved, ack_tog, out_full, in_pend, in_last;

  assign fire     = eval_pend & ~in_load;
  assign moved    = (hs_q != hs_last);
  assign ack_tog  = (hs_q.ack_n != hs_last.ack_n);
  assign out_full = (out_idx >= FULL);
  assign in_pend  = (in_idx < in_len_q);
  assign in_last  = ((in_idx + 1'b1) >= in_len_q);

  assign in_rd_addr = in_idx[AW-1:0];
  assign ob_addr    = out_idx[AW-1:0];
  assign ob_wdata   = sd_q;
  assign ob_we      = fire & ~hs_q.tip_n & tx_mode & moved & ~out_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q      <= HS_IDLE;
      hs_last   <= HS_IDLE;
      tx_mode   <= 1'b0;
      eval_pend <= 1'b0;
      sd_q      <= '0;
      flag      <= 1'b0;
      req_n     <= 1'b1;
      out_idx   <= '0;
      in_idx    <= '0;
      in_len_q  <= '0;
      pkt_done  <= 1'b0;
      pkt_len   <= '0;
    end else begin
      pkt_done  <= 1'b0;
      if (hs_we)   hs_q    <= hs_in;
      if (mode_we) tx_mode <= mode_tx;
      // a commit defers any pending evaluation by one cycle
      eval_pend <= hs_we | mode_we | in_load | (eval_pend & in_load);
      if (sd_we)    sd_q <= sd_wdata;
      if (flag_clr) flag <= 1'b0;
      if (in_load) begin
        in_idx   <= '0;
        in_len_q <= (in_len > FULL) ? FULL : in_len;
        flag     <= 1'b1;
      end
      if (fire) begin
        hs_last <= hs_q;
        if (!hs_q.tip_n) begin
          if (tx_mode) begin
            if (moved && !out_full) begin
              out_idx <= out_idx + 1'b1;
              flag    <= 1'b1;
            end
          end else if (moved && in_pend) begin
            sd_q   <= in_rd_data;
            in_idx <= in_idx + 1'b1;
            if (in_last) req_n <= 1'b1;
            flag   <= 1'b1;
          end
        end else if (hs_last.tip_n && ack_tog) begin
          req_n <= hs_q.ack_n;
          flag  <= 1'b1;
        end else begin
          if (!hs_last.tip_n) begin
            flag <= 1'b1;
            if (out_idx != '0) begin
              pkt_done <= 1'b1;
              pkt_len  <= out_idx;
            end
            out_idx <= '0;
          end
          if (in_pend) req_n <= 1'b0;
        end
      end
    end
  end

  AST_OUT_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_idx <= FULL); // R4
  AST_IN_BOUND: assert property (@(posedge clk) disable iff (rst)
    in_idx <= in_len_q); // R5
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> flag); // R8
  AST_LOAD_REWIND: assert property (@(posedge clk) disable iff (rst)
    in_load |=> (in_idx == '0)); // R10
  AST_REQ_ON_EVAL: assert property (@(posedge clk) disable iff (rst)
    (req_n != $past(req_n)) |-> $past(fire)); // R12
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !in_load && !eval_pend) |=> !flag); // R11
endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int IW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hs_we,
  input  logic          hs_tip_n,
  input  logic          hs_ack_n,
  input  logic          mode_we,
  input  logic          mode_host_tx,
  input  logic          sd_we,
  input  logic [DW-1:0] sd_wdata,
  input  logic          flag_clr,
  input  logic          in_wr_en,
  input  logic [AW-1:0] in_wr_addr,
  input  logic [DW-1:0] in_wr_data,
  input  logic          in_load,
  input  logic [IW-1:0] in_len,
  input  logic [AW-1:0] out_rd_addr,
  output logic [DW-1:0] out_rd_data,
  output logic          req_n,
  output logic [DW-1:0] sd_q,
  output logic          sr_flag,
  output logic          pkt_done,
  output logic [IW-1:0] pkt_len
);
  hs_t           hs_in;
  logic [AW-1:0] in_rd_addr, ob_addr;
  logic [DW-1:0] in_rd_data, ob_wdata, ob_rd_data;
  logic          ob_we;

  assign hs_in = '{tip_n: hs_tip_n, ack_n: hs_ack_n};

  hsk_buf #(.DEPTH(DEPTH), .DW(DW)) i_inbuf (
    .clk(clk), .we(in_wr_en), .waddr(in_wr_addr), .wdata(in_wr_data),
    .raddr(in_rd_addr), .rdata(in_rd_data)
  );

  hsk_buf #(.DEPTH(DEPTH), .DW(DW)) i_outbuf (
    .clk(clk), .we(ob_we), .waddr(ob_addr), .wdata(ob_wdata),
    .raddr(out_rd_addr), .rdata(ob_rd_data)
  );

  hsk_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_ctrl (
    .clk(clk), .rst(rst), .hs_we(hs_we), .hs_in(hs_in),
    .mode_we(mode_we), .mode_tx(mode_host_tx),
    .sd_we(sd_we), .sd_wdata(sd_wdata), .flag_clr(flag_clr),
    .in_load(in_load), .in_len(in_len),
    .in_rd_data(in_rd_data), .in_rd_addr(in_rd_addr),
    .ob_we(ob_we), .ob_addr(ob_addr), .ob_wdata(ob_wdata),
    .req_n(req_n), .sd_q(sd_q), .flag(sr_flag),
    .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  always_ff @(posedge clk) begin
    if (rst) out_rd_data <= '0;
    else     out_rd_data <= ob_rd_data;
  end
endmodule

// File: tb/test_hsk_xfer_engine.sv
module test_hsk_xfer_engine;
  logic       clk = 1'b0, rst = 1'b1;
  logic       hs_we = 0, hs_tip_n = 1, hs_ack_n = 1, mode_we = 0, mode_host_tx = 0;
  logic       sd_we = 0, flag_clr = 0, in_wr_en = 0, in_load = 0;
  logic [7:0] sd_wdata = 0, in_wr_data = 0;
  logic [3:0] in_wr_addr = 0, out_rd_addr = 0;
  logic [4:0] in_len = 0;
  logic [7:0] out_rd_data, sd_q;
  logic       req_n, sr_flag, pkt_done;
  logic [4:0] pkt_len;
  int         errs = 0, checks = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  hsk_xfer_engine i_hsk_xfer_engine (
    .clk(clk), .rst(rst), .hs_we(hs_we), .hs_tip_n(hs_tip_n), .hs_ack_n(hs_ack_n),
    .mode_we(mode_we), .mode_host_tx(mode_host_tx), .sd_we(sd_we), .sd_wdata(sd_wdata),
    .flag_clr(flag_clr), .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr),
    .in_wr_data(in_wr_data), .in_load(in_load), .in_len(in_len),
    .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data), .req_n(req_n),
    .sd_q(sd_q), .sr_flag(sr_flag), .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // write handshake pair, return after the evaluation edge
  task automatic hs(input logic tip, input logic ack);
    hs_we = 1; hs_tip_n = tip; hs_ack_n = ack;
    @(negedge clk); hs_we = 0;
    @(negedge clk);
  endtask

  task automatic mode(input logic tx);
    mode_we = 1; mode_host_tx = tx;
    @(negedge clk); mode_we = 0;
    @(negedge clk);
  endtask

  task automatic sdw(input logic [7:0] v);
    sd_we = 1; sd_wdata = v;
    @(negedge clk); sd_we = 0;
  endtask

  task automatic clr();
    flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic inw(input logic [3:0] a, input logic [7:0] v);
    in_wr_en = 1; in_wr_addr = a; in_wr_data = v;
    @(negedge clk); in_wr_en = 0;
  endtask

  task automatic load(input logic [4:0] n);
    in_load = 1; in_len = n;
    @(negedge clk); in_load = 0;
    @(negedge clk);
  endtask

  task automatic rdout(input logic [3:0] a, output logic [7:0] v);
    out_rd_addr = a;
    @(negedge clk); v = out_rd_data;
  endtask

  task automatic t_reset();
    chk("R1 req_n", req_n, 1);
    chk("R1 flag", sr_flag, 0);
    chk("R1 sd_q", sd_q, 0);
    chk("R1 done", pkt_done, 0);
    chk("R1 len", pkt_len, 0);
  endtask

  task automatic t_host_tx();
    logic [7:0] v;
    mode(1);
    sdw(8'hA1);
    // R12: nothing changes at the capture edge, only one edge later
    hs_we = 1; hs_tip_n = 0; hs_ack_n = 1;
    @(negedge clk); hs_we = 0;
    chk("R12 flag before eval", sr_flag, 0);
    @(negedge clk);
    chk("R2 R12 flag after first byte", sr_flag, 1);
    clr(); sdw(8'hB2); hs(0, 0);
    chk("R2 flag second byte", sr_flag, 1);
    clr(); sdw(8'hC3); hs(0, 1);
    clr(); hs(0, 1);
    chk("R3 no change no flag", sr_flag, 0);
    hs(1, 1);
    chk("R8 done pulse", pkt_done, 1);
    chk("R8 len 3", pkt_len, 3);
    chk("R8 flag at end", sr_flag, 1);
    @(negedge clk);
    chk("R8 done one cycle", pkt_done, 0);
    rdout(0, v); chk("R2 slot0", v, 8'hA1);
    rdout(1, v); chk("R2 slot1", v, 8'hB2);
    rdout(2, v); chk("R2 slot2", v, 8'hC3);
  endtask

  task automatic t_empty_end();
    mode(0);
    hs(0, 1);
    clr();
    hs(1, 1);
    chk("R8 flag on empty end", sr_flag, 1);
    chk("R8 no done when empty", pkt_done, 0);
    chk("R8 len kept", pkt_len, 3);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    mode(1);
    for (int i = 0; i < 17; i++) begin
      sdw(8'(8'h40 + i));
      if (i == 16) clr();
      hs(0, (i % 2 == 0) ? 1'b1 : 1'b0);
    end
    chk("R4 no flag when full", sr_flag, 0);
    hs(1, 1);
    chk("R4 done full", pkt_done, 1);
    chk("R4 len 16", pkt_len, 16);
    rdout(15, v); chk("R4 slot15", v, 8'h4F);
    rdout(0, v);  chk("R4 slot0 not overwritten", v, 8'h40);
  endtask

  task automatic t_dev_tx();
    mode(0);
    inw(0, 8'h11); inw(1, 8'h22); inw(2, 8'h33);
    clr();
    load(3);
    chk("R9 req low pending", req_n, 0);
    chk("R10 flag on load", sr_flag, 1);
    clr(); hs(0, 1);
    chk("R5 byte0", sd_q, 8'h11);
    chk("R5 flag", sr_flag, 1);
    hs(0, 0);
    chk("R5 byte1", sd_q, 8'h22);
    chk("R6 req still low", req_n, 0);
    hs(0, 1);
    chk("R5 byte2", sd_q, 8'h33);
    chk("R6 req high after last", req_n, 1);
    clr(); hs(0, 0);
    chk("R5 no byte left no flag", sr_flag, 0);
    chk("R5 sd kept", sd_q, 8'h33);
    hs(1, 1);
    chk("R8 flag end rx", sr_flag, 1);
    chk("R8 no done rx", pkt_done, 0);
    inw(0, 8'h55); inw(1, 8'h66);
    load(2);
    chk("R9 req low again", req_n, 0);
    hs(0, 1);
    chk("R10 rewound index", sd_q, 8'h55);
    hs(1, 1);
    chk("R9 req low idle pending", req_n, 0);
  endtask

  task automatic t_sync();
    load(0);
    clr();
    hs(1, 0);
    chk("R7 req follows ack low", req_n, 0);
    chk("R7 flag", sr_flag, 1);
    hs(1, 1);
    chk("R7 req follows ack high", req_n, 1);
    hs(1, 0);
    chk("R7 req follows ack low again", req_n, 0);
  endtask

  task automatic t_flag();
    clr();
    chk("R11 clear", sr_flag, 0);
    flag_clr = 1; in_load = 1; in_len = 0;
    @(negedge clk); flag_clr = 0; in_load = 0;
    chk("R11 set wins", sr_flag, 1);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_host_tx();
    t_empty_end();
    t_overflow();
    t_dev_tx();
    t_sync();
    t_flag();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule